// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is the translation array of a memory management unit. It holds a parameterised number of fully associative entries. Each entry maps an aligned pair of neighbouring virtual pages, one even and one odd, and gives each page its own frame number, valid flag and dirty flag. Every entry has its own page-size mask. That mask sets two things: how many virtual page-number bits take part in the compare, and which address bit picks the even or the odd half.

Software or a refill engine loads entries through a single write port by giving an index and the full entry contents. A requester pulses a start strobe with a virtual address, the current address-space identifier, a read/write flag and a quiet-probe flag. All entries are compared in parallel, and the result is registered one cycle later. The result is either a physical address with a writable indication, or an exception code with a refill indication. Segment decoding, the refill handler and any cache sit outside this block.

Top module: `jtlb_pair_xlate`

## Requirements
- R1: After reset, rs_done, rs_ok and rs_exc are low, and every entry holds zero: mask 0, VPN2 0, ASID 0, global 0, and both halves with frame 0 and valid and dirty clear.
- R2: Each cycle with lk_start high gives rs_done high in the next cycle only. rs_done is low in every other cycle, and rs_ok and rs_exc are never high while rs_done is low.
- R3: The 14-bit mask field covers address bits 26..13. Its legal values are 2k contiguous ones from bit 0, for k = 0..7, and they give a page shift of 12+2k. A write with any other mask leaves the entry unchanged and drives wr_mask_bad high in that cycle. A write with a legal mask to an index below N_ENT replaces the whole entry at the clock edge.
- R4: An entry's VPN2 is compared with the address bits at position shift+1 and above. Address bit [shift] set selects the odd half (lo1 fields), and clear selects the even half (lo0 fields).
- R5: A VPN2 match counts as a hit only if the entry's ASID equals lk_asid or the entry's global bit is set.
- R6: On success, rs_pa equals the selected frame number shifted left by 12, ORed with the address bits below the page shift.
- R7: A lookup succeeds when there is a hit, the selected valid bit is set, and the access is either a read or to a dirty page. rs_ok is then 1 and rs_writable is the selected dirty bit. On failure, rs_ok, rs_writable and rs_pa are 0.
- R8: A hit on a half whose valid bit is clear raises an exception with code 2 for a read or code 3 for a write, and with rs_refill = 0.
- R9: A write that hits a valid half whose dirty bit is clear raises code 1 (modified) with rs_refill = 0.
- R10: When no entry hits, an exception is raised with code 2 for a read or code 3 for a write, and with rs_refill = 1.
- R11: With lk_noexc set, a failing lookup reports rs_ok = 0, rs_exc = 0, rs_code = 0 and rs_refill = 0.
- R12: When several entries hit, the lowest-indexed one supplies the result.
- R13: A lookup started in the same cycle as a write sees the array as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_mask | input | 14 | Page-size mask, address bits 26..13 |
| wr_vpn2 | input | VA_W-13 | Virtual page-pair number (address bits VA_W-1..13) |
| wr_asid | input | ASID_W | Entry address-space identifier |
| wr_g | input | 1 | Global: ignore ASID |
| wr_pfn0 | input | PFN_W | Even-page frame number |
| wr_v0 | input | 1 | Even-page valid |
| wr_d0 | input | 1 | Even-page dirty (writable) |
| wr_pfn1 | input | PFN_W | Odd-page frame number |
| wr_v1 | input | 1 | Odd-page valid |
| wr_d1 | input | 1 | Odd-page dirty (writable) |
| wr_mask_bad | output | 1 | Current write rejected for an illegal mask |
| lk_start | input | 1 | Lookup request strobe |
| lk_va | input | VA_W | Virtual address |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | 1 = store access, 0 = load |
| lk_noexc | input | 1 | Quiet probe: report failure without an exception |
| rs_done | output | 1 | Result valid |
| rs_ok | output | 1 | Translation succeeded |
| rs_writable | output | 1 | Page is read/write (dirty set) |
| rs_pa | output | PFN_W+12 | Physical address |
| rs_exc | output | 1 | Exception raised |
| rs_code | output | 2 | 0 none, 1 modified, 2 load, 3 store |
| rs_refill | output | 1 | Exception came from a miss |

## Verification
The assertions assume that lk_start is sampled with stable lookup fields, and that rs_done follows only from a start in the previous cycle. The checks on the modified code and on quiet probes depend on this, because they look back one cycle at lk_write and lk_noexc. They also assume the array is built only through the write port, so every stored mask is legal. The stimulus drives inputs only between clock edges and holds each request for exactly one cycle. It sends illegal masks only to show that they are rejected, and it keeps random page numbers in a small window so that overlapping entries, global hits and mixed page sizes all occur.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;
  localparam int PM_W = 14;

  typedef enum logic [1:0] {
    XC_NONE  = 2'd0,
    XC_MOD   = 2'd1,
    XC_LOAD  = 2'd2,
    XC_STORE = 2'd3
  } xc_code_e;

  // legal masks: an even count of contiguous ones starting at bit 0
  function automatic logic pm_legal(input logic [PM_W-1:0] m);
    int c;
    c = $countones(m);
    return ((((m + 1'b1) & m) == '0) && ((c % 2) == 0));
  endfunction

  function automatic int pm_shift(input logic [PM_W-1:0] m);
    return 12 + $countones(m);
  endfunction

  // byte-offset mask over address bits 25..0
  function automatic logic [PM_W+11:0] pm_offset(input logic [PM_W-1:0] m);
    return {m, 12'hFFF};
  endfunction
endpackage

// File: rtl/jtlb_store.sv
module jtlb_store
  import jtlb_pkg::*;
#(
  parameter int N_ENT  = 48,
  parameter int IDX_W  = 6,
  parameter int VPN2_W = 27,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PM_W-1:0]   wr_mask,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic              wr_v0,
  input  logic              wr_d0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic              wr_v1,
  input  logic              wr_d1,
  output logic              wr_mask_bad,
  output logic [PM_W-1:0]   e_mask [N_ENT],
  output logic [VPN2_W-1:0] e_vpn2 [N_ENT],
  output logic [ASID_W-1:0] e_asid [N_ENT],
  output logic              e_g    [N_ENT],
  output logic [PFN_W-1:0]  e_pfn0 [N_ENT],
  output logic              e_v0   [N_ENT],
  output logic              e_d0   [N_ENT],
  output logic [PFN_W-1:0]  e_pfn1 [N_ENT],
  output logic              e_v1   [N_ENT],
  output logic              e_d1   [N_ENT]
);
  logic wr_ok;
  assign wr_ok       = wr_en && pm_legal(wr_mask);
  assign wr_mask_bad = wr_en && !wr_ok;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic sel;
    assign sel = wr_ok && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_mask[i] <= '0;
        e_vpn2[i] <= '0;
        e_asid[i] <= '0;
        e_g[i]    <= 1'b0;
        e_pfn0[i] <= '0;
        e_v0[i]   <= 1'b0;
        e_d0[i]   <= 1'b0;
        e_pfn1[i] <= '0;
        e_v1[i]   <= 1'b0;
        e_d1[i]   <= 1'b0;
      end else if (sel) begin
        e_mask[i] <= wr_mask;
        e_vpn2[i] <= wr_vpn2;
        e_asid[i] <= wr_asid;
        e_g[i]    <= wr_g;
        e_pfn0[i] <= wr_pfn0;
        e_v0[i]   <= wr_v0;
        e_d0[i]   <= wr_d0;
        e_pfn1[i] <= wr_pfn1;
        e_v1[i]   <= wr_v1;
        e_d1[i]   <= wr_d1;
      end
    end

    // R3
    bad_mask_keeps_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mask_bad && wr_idx == IDX_W'(i)) |=> ($stable(e_mask[i]) && $stable(e_vpn2[i])
                                                && $stable(e_pfn0[i])));
  end
endmodule

// File: rtl/jtlb_cmp.sv
module jtlb_cmp
  import jtlb_pkg::*;
#(
  parameter int VPN2_W = 27,
  parameter int ASID_W = 8
) (
  input  logic [PM_W-1:0]   e_mask,
  input  logic [VPN2_W-1:0] e_vpn2,
  input  logic [ASID_W-1:0] e_asid,
  input  logic              e_g,
  input  logic [VPN2_W-1:0] q_vpn2,
  input  logic [ASID_W-1:0] q_asid,
  output logic              hit
);
  logic [VPN2_W-1:0] care;
  logic              vpn_eq;
  logic              asid_eq;

  assign care    = ~{{(VPN2_W-PM_W){1'b0}}, e_mask};
  assign vpn_eq  = ((e_vpn2 ^ q_vpn2) & care) == '0;
  assign asid_eq = e_g || (e_asid == q_asid);
  assign hit     = vpn_eq && asid_eq;
endmodule

// File: rtl/jtlb_first.sv
module jtlb_first #(
  parameter int N_ENT = 48,
  parameter int IDX_W = 6
) (
  input  logic [N_ENT-1:0] hit,
  output logic [N_ENT-1:0] grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (hit[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/jtlb_pair_xlate.sv
module jtlb_pair_xlate
  import jtlb_pkg::*;
#(
  parameter int N_ENT  = 48,
  parameter int VA_W   = 40,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 24,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int VPN2_W = VA_W - 13,
  localparam int PA_W   = PFN_W + 12,
  localparam int VA_IW  = $clog2(VA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [13:0]       wr_mask,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_g,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic              wr_v0,
  input  logic              wr_d0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic              wr_v1,
  input  logic              wr_d1,
  output logic              wr_mask_bad,
  input  logic              lk_start,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              lk_noexc,
  output logic              rs_done,
  output logic              rs_ok,
  output logic              rs_writable,
  output logic [PA_W-1:0]   rs_pa,
  output logic              rs_exc,
  output logic [1:0]        rs_code,
  output logic              rs_refill
);
  logic [PM_W-1:0]   e_mask [N_ENT];
  logic [VPN2_W-1:0] e_vpn2 [N_ENT];
  logic [ASID_W-1:0] e_asid [N_ENT];
  logic              e_g    [N_ENT];
  logic [PFN_W-1:0]  e_pfn0 [N_ENT];
  logic              e_v0   [N_ENT];
  logic              e_d0   [N_ENT];
  logic [PFN_W-1:0]  e_pfn1 [N_ENT];
  logic              e_v1   [N_ENT];
  logic              e_d1   [N_ENT];

  jtlb_store #(.N_ENT(N_ENT), .IDX_W(IDX_W), .VPN2_W(VPN2_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_pfn0(wr_pfn0), .wr_v0(wr_v0), .wr_d0(wr_d0),
    .wr_pfn1(wr_pfn1), .wr_v1(wr_v1), .wr_d1(wr_d1),
    .wr_mask_bad(wr_mask_bad),
    .e_mask(e_mask), .e_vpn2(e_vpn2), .e_asid(e_asid), .e_g(e_g),
    .e_pfn0(e_pfn0), .e_v0(e_v0), .e_d0(e_d0),
    .e_pfn1(e_pfn1), .e_v1(e_v1), .e_d1(e_d1)
  );

  // parallel compare, one cell per entry
  logic [VPN2_W-1:0] q_vpn2;
  logic [N_ENT-1:0]  hit_vec;
  assign q_vpn2 = lk_va[VA_W-1:13];

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    jtlb_cmp #(.VPN2_W(VPN2_W), .ASID_W(ASID_W)) u_cmp (
      .e_mask(e_mask[i]), .e_vpn2(e_vpn2[i]), .e_asid(e_asid[i]), .e_g(e_g[i]),
      .q_vpn2(q_vpn2), .q_asid(lk_asid), .hit(hit_vec[i])
    );
  end

  logic [N_ENT-1:0] grant;
  logic [IDX_W-1:0] hit_idx;
  logic             hit_any;

  jtlb_first #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_first (
    .hit(hit_vec), .grant(grant), .idx(hit_idx), .any(hit_any)
  );

  // R12
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((|hit_vec) == hit_any));

  function automatic logic [PA_W-1:0] pa_make(input logic [PFN_W-1:0] pfn,
                                               input logic [25:0] va_lo,
                                               input logic [PM_W-1:0] m);
    return {pfn, 12'h000} | PA_W'(va_lo & pm_offset(m));
  endfunction

  // half selection for the winning entry
  logic [PM_W-1:0]  sel_mask;
  logic             sel_odd;
  logic             sel_v;
  logic             sel_d;
  logic [PFN_W-1:0] sel_pfn;

  always_comb begin
    sel_mask = e_mask[hit_idx];
    sel_odd  = lk_va[VA_IW'(pm_shift(sel_mask))];
    sel_v    = sel_odd ? e_v1[hit_idx]   : e_v0[hit_idx];
    sel_d    = sel_odd ? e_d1[hit_idx]   : e_d0[hit_idx];
    sel_pfn  = sel_odd ? e_pfn1[hit_idx] : e_pfn0[hit_idx];
  end

  // outcome decode
  logic            ok_c, fail_c, exc_c, refill_c, wbl_c;
  xc_code_e        code_c;
  logic [PA_W-1:0] pa_c;

  always_comb begin
    ok_c     = 1'b0;
    fail_c   = 1'b1;
    refill_c = 1'b0;
    wbl_c    = 1'b0;
    pa_c     = '0;
    code_c   = lk_write ? XC_STORE : XC_LOAD;
    if (!hit_any) begin
      refill_c = 1'b1;
    end else if (!sel_v) begin
      refill_c = 1'b0;
    end else if (lk_write && !sel_d) begin
      code_c = XC_MOD;
    end else begin
      ok_c   = 1'b1;
      fail_c = 1'b0;
      wbl_c  = sel_d;
      pa_c   = pa_make(sel_pfn, lk_va[25:0], sel_mask);
      code_c = XC_NONE;
    end
    exc_c = fail_c && !lk_noexc;
    if (!exc_c) begin
      code_c   = XC_NONE;
      refill_c = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_done     <= 1'b0;
      rs_ok       <= 1'b0;
      rs_exc      <= 1'b0;
      rs_writable <= 1'b0;
      rs_pa       <= '0;
      rs_code     <= 2'd0;
      rs_refill   <= 1'b0;
    end else begin
      rs_done <= lk_start;
      rs_ok   <= lk_start && ok_c;
      rs_exc  <= lk_start && exc_c;
      if (lk_start) begin
        rs_writable <= wbl_c;
        rs_pa       <= pa_c;
        rs_code     <= code_c;
        rs_refill   <= refill_c;
      end
    end
  end

  // R2
  result_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_ok || rs_exc) |-> rs_done);
  // R7
  ok_excl_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rs_ok && rs_exc));
  // R7
  write_ok_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_ok && $past(lk_write)) |-> rs_writable);
  // R9
  mod_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_exc && rs_code == 2'd1) |-> $past(lk_write));
  // R10
  miss_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_start && !hit_any && !lk_noexc) |=> (rs_exc && rs_refill));
  // R11
  quiet_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_done && $past(lk_noexc)) |-> !rs_exc);
endmodule

// File: tb/jtlb_pair_xlate_bench.sv
module jtlb_pair_xlate_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N    = 48;
  localparam int VA_W = 40;
  localparam int PFNW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              wr_en = 0;
  logic [5:0]        wr_idx = 0;
  logic [13:0]       wr_mask = 0;
  logic [VA_W-14:0]  wr_vpn2 = 0;
  logic [7:0]        wr_asid = 0;
  logic              wr_g = 0;
  logic [PFNW-1:0]   wr_pfn0 = 0, wr_pfn1 = 0;
  logic              wr_v0 = 0, wr_d0 = 0, wr_v1 = 0, wr_d1 = 0;
  logic              wr_mask_bad;
  logic              lk_start = 0;
  logic [VA_W-1:0]   lk_va = 0;
  logic [7:0]        lk_asid = 0;
  logic              lk_write = 0, lk_noexc = 0;
  logic              rs_done, rs_ok, rs_writable, rs_exc, rs_refill;
  logic [PFNW+11:0]  rs_pa;
  logic [1:0]        rs_code;

  jtlb_pair_xlate u_jtlb_pair_xlate (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_pfn0(wr_pfn0), .wr_v0(wr_v0), .wr_d0(wr_d0),
    .wr_pfn1(wr_pfn1), .wr_v1(wr_v1), .wr_d1(wr_d1), .wr_mask_bad(wr_mask_bad),
    .lk_start(lk_start), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
    .lk_noexc(lk_noexc), .rs_done(rs_done), .rs_ok(rs_ok), .rs_writable(rs_writable),
    .rs_pa(rs_pa), .rs_exc(rs_exc), .rs_code(rs_code), .rs_refill(rs_refill)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference array
  longint m_mask [N], m_vpn2 [N], m_asid [N], m_p0 [N], m_p1 [N];
  bit     m_g [N], m_v0 [N], m_d0 [N], m_v1 [N], m_d1 [N];

  task automatic chk(input bit good, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int page_shift(input longint m);
    int s = -1;
    for (int k = 0; k < 8; k++) if (m == (64'd1 << (2*k)) - 1) s = 12 + 2*k;
    return s;
  endfunction

  task automatic model_look(input longint va, input longint asid, input bit wr, input bit nx,
                            output bit ok, output bit wbl, output longint pa,
                            output bit exc, output int code, output bit refill);
    int hit = -1;
    int sh = 12;
    bit odd, v, d;
    longint pfn;
    for (int i = 0; i < N; i++) begin
      int s = page_shift(m_mask[i]);
      if (hit < 0 && ((va >> (s+1)) == ((m_vpn2[i] << 13) >> (s+1))) &&
          (m_g[i] || m_asid[i] == asid)) begin
        hit = i;
        sh = s;
      end
    end
    ok = 0; wbl = 0; pa = 0; exc = 0; code = 0; refill = 0;
    if (hit < 0) begin
      exc = 1; refill = 1; code = wr ? 3 : 2;
    end else begin
      odd = (va >> sh) & 1;
      v   = odd ? m_v1[hit] : m_v0[hit];
      d   = odd ? m_d1[hit] : m_d0[hit];
      pfn = odd ? m_p1[hit] : m_p0[hit];
      if (!v) begin exc = 1; code = wr ? 3 : 2; end
      else if (wr && !d) begin exc = 1; code = 1; end
      else begin
        ok = 1; wbl = d;
        pa = (pfn << 12) | (va & ((64'd1 << sh) - 1));
      end
    end
    if (nx && exc) begin exc = 0; code = 0; refill = 0; end
  endtask

  // one clock: predict, apply the write to the model, then compare after the edge
  task automatic step(input string req);
    bit e_ok, e_wbl, e_exc, e_ref, e_done;
    longint e_pa;
    int e_code;
    #1;
    e_done = lk_start;
    model_look(lk_va, lk_asid, lk_write, lk_noexc, e_ok, e_wbl, e_pa, e_exc, e_code, e_ref);
    if (wr_en) begin
      bit legal = page_shift(wr_mask) >= 0;
      chk(wr_mask_bad == !legal, "R3", "wr_mask_bad", wr_mask_bad, !legal);
      if (legal && wr_idx < N) begin
        m_mask[wr_idx] = wr_mask; m_vpn2[wr_idx] = wr_vpn2; m_asid[wr_idx] = wr_asid;
        m_g[wr_idx] = wr_g; m_p0[wr_idx] = wr_pfn0; m_v0[wr_idx] = wr_v0; m_d0[wr_idx] = wr_d0;
        m_p1[wr_idx] = wr_pfn1; m_v1[wr_idx] = wr_v1; m_d1[wr_idx] = wr_d1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(rs_done == e_done, "R2", "rs_done", rs_done, e_done);
    if (e_done) begin
      chk(rs_ok == e_ok, req, "rs_ok", rs_ok, e_ok);
      chk(rs_exc == e_exc, req, "rs_exc", rs_exc, e_exc);
      chk(rs_code == e_code, req, "rs_code", rs_code, e_code);
      chk(rs_refill == e_ref, req, "rs_refill", rs_refill, e_ref);
      chk(rs_writable == e_wbl, req, "rs_writable", rs_writable, e_wbl);
      chk(rs_pa == e_pa, req, "rs_pa", rs_pa, e_pa);
    end else begin
      chk(!rs_ok && !rs_exc, "R2", "ok/exc idle", {rs_ok, rs_exc}, 0);
    end
  endtask

  task automatic set_wr(input int idx, input longint mask, input longint vpn2, input int asid,
                        input bit g, input longint p0, input bit v0, input bit d0,
                        input longint p1, input bit v1, input bit d1);
    wr_en = 1; wr_idx = 6'(idx); wr_mask = 14'(mask); wr_vpn2 = 27'(vpn2);
    wr_asid = 8'(asid); wr_g = g; wr_pfn0 = 24'(p0); wr_v0 = v0; wr_d0 = d0;
    wr_pfn1 = 24'(p1); wr_v1 = v1; wr_d1 = d1;
  endtask

  task automatic set_lk(input longint va, input int asid, input bit w, input bit nx);
    lk_start = 1; lk_va = 40'(va); lk_asid = 8'(asid); lk_write = w; lk_noexc = nx;
  endtask

  task automatic idle_in();
    wr_en = 0; lk_start = 0;
  endtask

  task automatic look(input longint va, input int asid, input bit w, input bit nx,
                      input string req);
    set_lk(va, asid, w, nx);
    step(req);
    idle_in();
  endtask

  task automatic put(input int idx, input longint mask, input longint vpn2, input int asid,
                     input bit g, input longint p0, input bit v0, input bit d0,
                     input longint p1, input bit v1, input bit d1, input string req);
    set_wr(idx, mask, vpn2, asid, g, p0, v0, d0, p1, v1, d1);
    step(req);
    idle_in();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_mask[i] = 0; m_vpn2[i] = 0; m_asid[i] = 0; m_p0[i] = 0; m_p1[i] = 0;
      m_g[i] = 0; m_v0[i] = 0; m_d0[i] = 0; m_v1[i] = 0; m_d1[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!rs_done && !rs_ok && !rs_exc, "R1", "outputs after reset",
        {rs_done, rs_ok, rs_exc}, 0);
    // R1 zero entries: vpn2 0 / asid 0 hits an invalid entry
    look(64'h123, 0, 0, 0, "R1");

    // 4 KB pair, R4 R6 R7
    put(5, 0, 'h100, 3, 0, 'hAAAA, 1, 1, 'hBBBB, 1, 0, "R3");
    look(64'h200123, 3, 0, 0, "R6");
    look(64'h200123, 3, 1, 0, "R7");
    look(64'h201456, 3, 0, 0, "R4");
    look(64'h201456, 3, 1, 0, "R9");
    look(64'h200123, 4, 0, 0, "R5");
    // 16 MB pair, global bit
    put(7, 'hFFF, 'h2000, 0, 1, 'h1000, 1, 1, 'h3000, 1, 1, "R3");
    look(64'h40ABCDE, 9, 0, 0, "R5");
    look(64'h50ABCDE, 9, 1, 0, "R4");
    // 64 MB pair
    put(9, 'h3FFF, 'h8000, 1, 0, 'h4000, 1, 0, 'h8000, 1, 1, "R3");
    look(64'h13FFFFFF, 1, 0, 0, "R6");
    look(64'h11234567, 1, 0, 0, "R6");
    // invalid half
    put(11, 0, 'h300, 2, 0, 'h11, 0, 1, 'h22, 1, 1, "R3");
    look(64'h600010, 2, 0, 0, "R8");
    look(64'h600010, 2, 1, 0, "R8");
    // misses
    look(64'hEEE000, 2, 1, 0, "R10");
    look(64'hEEE000, 2, 0, 0, "R10");
    // quiet probes
    look(64'hEEE000, 2, 1, 1, "R11");
    look(64'h201456, 3, 1, 1, "R11");
    look(64'h600010, 2, 0, 1, "R11");
    // lowest index wins
    put(30, 0, 'h400, 5, 0, 'h3030, 1, 1, 'h3131, 1, 1, "R12");
    put(20, 0, 'h400, 5, 0, 'h2020, 1, 1, 'h2121, 1, 1, "R12");
    look(64'h800010, 5, 0, 0, "R12");
    // illegal mask rejected, old mapping still in place
    put(20, 'h5, 'h401, 5, 0, 'h9999, 1, 1, 'h9999, 1, 1, "R3");
    look(64'h800010, 5, 0, 0, "R3");
    put(20, 'h2, 'h401, 5, 0, 'h9999, 1, 1, 'h9999, 1, 1, "R3");
    look(64'h800010, 5, 0, 0, "R3");
    // same-cycle write and lookup
    set_wr(5, 0, 'h100, 3, 0, 'hCCCC, 1, 1, 'hBBBB, 1, 0);
    set_lk(64'h200123, 3, 0, 0);
    step("R13");
    idle_in();
    look(64'h200123, 3, 0, 0, "R13");

    // random mix against the model
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 5;
      if (r == 0 || r == 4) begin
        int k = $urandom % 4;
        longint mk = (($urandom % 16) == 0) ? 64'h5 : ((64'd1 << (2*k)) - 1);
        set_wr($urandom % N, mk, 'h100 + ($urandom % 8), $urandom % 4, ($urandom % 4) == 0,
               $urandom % 'h10000, $urandom % 2, $urandom % 2,
               $urandom % 'h10000, $urandom % 2, $urandom % 2);
      end
      if (r == 1 || r == 2 || r == 4) begin
        longint va = ((64'h100 + ($urandom % 8)) << 13) | ($urandom % 'h4000);
        set_lk(va, $urandom % 4, $urandom % 2, ($urandom % 6) == 0);
      end
      step("R12");
      idle_in();
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual 0x1 expected 0x0");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule